// File: doc/BRIEF.md
# Flash Partition Access Guard

This block sits in front of an embedded flash and decides, access by access, whether the requesting domain may touch the addressed partition. There are two requesting domains, primary and secondary. The flash is split into sixteen equal partitions. Three 16-bit control vectors, one bit per partition, say who may do what:

- the owner vector names which domain owns the partition;
- the read-only vector takes write rights away from the owner;
- the other-read vector grants the domain that is not the owner read access.

The vectors come from quasi-static inputs. They are loaded into internal registers while reset is held and again while configuration mode is requested. At all other times they are frozen.

Each access presents a domain bit, a read/write flag and an address. One cycle later the block returns exactly one verdict: grant, error, or read-as-zero/write-dropped. Read-as-zero/write-dropped is only available to the primary domain, and only when its silent-mode control bit is set. Every refused access stores its address in a violation register and raises a sticky interrupt flag. The flag stays high until it is cleared.

Top module: `part_guard`

## Requirements
- R1: The partition index is the address field above the partition offset, where the offset is log2(PART_KB)+10 bits wide (bit 14 upward for 16 KB). Any field value of 15 or more uses control bit 15.
- R2: Owner bit value 0 names the primary domain and value 1 names the secondary domain; domain bit 0 is primary and 1 is secondary. The owner may always read, and may write only when the read-only bit of that partition is 0.
- R3: For the domain that is not the owner: if the other-read bit equals the owner bit, every access is refused. If the two bits differ, reads are granted and writes are refused.
- R4: The control vectors are loaded on every clock edge where reset or configuration mode is high. Otherwise they hold, so changes on the vector inputs have no effect on verdicts.
- R5: A refused access from the secondary domain always returns the error verdict.
- R6: A refused access from the primary domain returns the error verdict when silent mode is 0, and the read-as-zero/write-dropped verdict when silent mode is 1.
- R7: Every refused access loads its full address into the violation address output. A granted access leaves that output unchanged.
- R8: The violation flag is set by any refused access. It is cleared by the clear input only in a cycle with no refused access; setting wins over clearing.
- R9: The response is valid exactly one cycle after an access is presented. While valid, exactly one of grant, error and read-as-zero is high. While not valid, all three are low.
- R10: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; control vectors load while high |
| cfg_mode_i | input | 1 | Configuration mode; control vectors load while high |
| own_vec_i | input | NPART | Owner per partition (0 primary, 1 secondary) |
| ro_vec_i | input | NPART | Owner write-protect per partition |
| oth_rd_vec_i | input | NPART | Non-owner read selector per partition |
| silent_en_i | input | 1 | Primary-domain violations answer read-as-zero instead of error |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_dom_i | input | 1 | Requesting domain (0 primary, 1 secondary) |
| acc_write_i | input | 1 | 1 write, 0 read |
| acc_addr_i | input | ADDR_W | Flash byte address |
| viol_clr_i | input | 1 | Clear the violation flag |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_grant_o | output | 1 | Access granted |
| rsp_err_o | output | 1 | Access refused with error |
| rsp_raz_o | output | 1 | Access refused silently: read returns zero, write is dropped |
| viol_addr_o | output | ADDR_W | Address of the most recent refused access |
| viol_irq_o | output | 1 | Sticky violation flag |

## Verification
The bench loads several vector patterns through configuration mode. Under each pattern it sweeps every partition, both domains, both directions and both silent settings, and also sends addresses whose field runs past partition 15. A design with a missing clamp, or one that reads the wrong address bits, would pick the wrong control bit and give the wrong verdict. A design that compared the other-read bit against the domain instead of against the owner bit would grant reads the rules deny.

The bench also changes the vector inputs outside reset and outside configuration mode. A design that follows its inputs live would then change its verdicts. Finally, it clears the flag in the same cycle as a new violation. A design that let the clear win would drop that interrupt.

// File: rtl/part_guard_pkg.sv
package part_guard_pkg;
  typedef enum logic [1:0] {
    VERDICT_GRANT = 2'd0,
    VERDICT_ERR   = 2'd1,
    VERDICT_RAZ   = 2'd2
  } verdict_e;
endpackage

// File: rtl/part_map_regs.sv
module part_map_regs #(
  parameter int NPART = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode_i,
  input  logic [NPART-1:0] own_vec_i,
  input  logic [NPART-1:0] ro_vec_i,
  input  logic [NPART-1:0] oth_rd_vec_i,
  output logic [NPART-1:0] own_q,
  output logic [NPART-1:0] ro_q,
  output logic [NPART-1:0] oth_q
);
  // Loaded while reset is held (so the release edge keeps the last value)
  // and while configuration mode is active; frozen otherwise.
  always_ff @(posedge clk) begin
    if (rst || cfg_mode_i) begin
      own_q <= own_vec_i;
      ro_q  <= ro_vec_i;
      oth_q <= oth_rd_vec_i;
    end
  end
endmodule

// File: rtl/part_index.sv
module part_index #(
  parameter int IDX_W = 8,
  parameter int NPART = 16,
  localparam int SEL_W = $clog2(NPART)
) (
  input  logic [IDX_W-1:0] field_i,
  output logic [SEL_W-1:0] sel_o
);
  generate
    if (IDX_W > SEL_W) begin : g_clamp
      // Region beyond the last full partition folds onto the last entry.
      assign sel_o = (field_i >= IDX_W'(NPART-1)) ? SEL_W'(NPART-1)
                                                  : field_i[SEL_W-1:0];
    end else begin : g_direct
      assign sel_o = SEL_W'(field_i);
    end
  endgenerate
endmodule

// File: rtl/rights_eval.sv
module rights_eval
  import part_guard_pkg::*;
(
  input  logic     own_bit_i,
  input  logic     ro_bit_i,
  input  logic     oth_bit_i,
  input  logic     dom_i,
  input  logic     write_i,
  input  logic     silent_en_i,
  output verdict_e verdict_o
);
  logic is_owner;
  logic allow;

  always_comb begin
    is_owner = (dom_i == own_bit_i);
    if (is_owner) allow = !write_i || !ro_bit_i;
    else          allow = (oth_bit_i != own_bit_i) && !write_i;

    if (allow)                      verdict_o = VERDICT_GRANT;
    else if (dom_i || !silent_en_i) verdict_o = VERDICT_ERR;
    else                            verdict_o = VERDICT_RAZ;
  end
endmodule

// File: rtl/viol_log.sv
module viol_log #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              viol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] viol_addr_o,
  output logic              viol_irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_addr_o <= '0;
      viol_irq_o  <= 1'b0;
    end else begin
      if (viol_i) viol_addr_o <= addr_i;
      viol_irq_o <= viol_i || (viol_irq_o && !clr_i);
    end
  end
endmodule

// File: rtl/part_guard.sv
module part_guard
  import part_guard_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int PART_KB = 16,
  parameter int NPART   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode_i,
  input  logic [NPART-1:0]  own_vec_i,
  input  logic [NPART-1:0]  ro_vec_i,
  input  logic [NPART-1:0]  oth_rd_vec_i,
  input  logic              silent_en_i,
  input  logic              acc_valid_i,
  input  logic              acc_dom_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              viol_clr_i,
  output logic              rsp_valid_o,
  output logic              rsp_grant_o,
  output logic              rsp_err_o,
  output logic              rsp_raz_o,
  output logic [ADDR_W-1:0] viol_addr_o,
  output logic              viol_irq_o
);
  localparam int OFFS_W = $clog2(PART_KB) + 10;
  localparam int IDX_W  = ADDR_W - OFFS_W;
  localparam int SEL_W  = $clog2(NPART);

  logic [NPART-1:0] own_q, ro_q, oth_q;
  logic [SEL_W-1:0] sel;
  verdict_e         verdict;
  logic             viol_now;

  part_map_regs #(.NPART(NPART)) map_i (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i),
    .own_vec_i(own_vec_i), .ro_vec_i(ro_vec_i), .oth_rd_vec_i(oth_rd_vec_i),
    .own_q(own_q), .ro_q(ro_q), .oth_q(oth_q)
  );

  part_index #(.IDX_W(IDX_W), .NPART(NPART)) idx_i (
    .field_i(acc_addr_i[ADDR_W-1:OFFS_W]),
    .sel_o(sel)
  );

  rights_eval eval_i (
    .own_bit_i(own_q[sel]), .ro_bit_i(ro_q[sel]), .oth_bit_i(oth_q[sel]),
    .dom_i(acc_dom_i), .write_i(acc_write_i), .silent_en_i(silent_en_i),
    .verdict_o(verdict)
  );

  assign viol_now = acc_valid_i && (verdict != VERDICT_GRANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_raz_o   <= 1'b0;
    end else begin
      rsp_valid_o <= acc_valid_i;
      rsp_grant_o <= acc_valid_i && (verdict == VERDICT_GRANT);
      rsp_err_o   <= acc_valid_i && (verdict == VERDICT_ERR);
      rsp_raz_o   <= acc_valid_i && (verdict == VERDICT_RAZ);
    end
  end

  viol_log #(.ADDR_W(ADDR_W)) log_i (
    .clk(clk), .rst(rst), .viol_i(viol_now), .addr_i(acc_addr_i),
    .clr_i(viol_clr_i), .viol_addr_o(viol_addr_o), .viol_irq_o(viol_irq_o)
  );
endmodule

// File: rtl/part_guard_chk.sv
module part_guard_chk #(
  parameter int ADDR_W = 22,
  parameter int NPART  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_mode_i,
  input logic              silent_en_i,
  input logic              acc_valid_i,
  input logic              acc_dom_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_grant_o,
  input logic              rsp_err_o,
  input logic              rsp_raz_o,
  input logic [ADDR_W-1:0] viol_addr_o,
  input logic              viol_irq_o,
  input logic [3*NPART-1:0] map_q
);
  p_resp_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $countones({rsp_grant_o, rsp_err_o, rsp_raz_o}) == 1);
  p_resp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> !(rsp_grant_o || rsp_err_o || rsp_raz_o));
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i |=> rsp_valid_o);
  p_sec_no_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && acc_dom_i) |=> !rsp_raz_o);
  p_pri_err_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !acc_dom_i && !silent_en_i) |=> !rsp_raz_o);
  p_map_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode_i |=> $stable(map_q));
  p_viol_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !acc_dom_i && !silent_en_i) |=> (rsp_grant_o || viol_addr_o == $past(acc_addr_i)));
  p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !rsp_grant_o) |-> viol_irq_o);
endmodule

bind part_guard part_guard_chk #(.ADDR_W(ADDR_W), .NPART(NPART)) chk_i (
  .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i), .silent_en_i(silent_en_i),
  .acc_valid_i(acc_valid_i), .acc_dom_i(acc_dom_i), .acc_addr_i(acc_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_grant_o(rsp_grant_o), .rsp_err_o(rsp_err_o),
  .rsp_raz_o(rsp_raz_o), .viol_addr_o(viol_addr_o), .viol_irq_o(viol_irq_o),
  .map_q({own_q, ro_q, oth_q})
);

// File: tb/part_guard_tb_top.sv
module part_guard_tb_top;
  localparam int ADDR_W = 22;
  localparam int NPART  = 16;
  localparam int OFFS   = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0;
  logic [NPART-1:0] own_v = '0, ro_v = '0, oth_v = '0;
  logic silent = 1'b0;
  logic acc_valid = 1'b0, acc_dom = 1'b0, acc_write = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic viol_clr = 1'b0;
  logic rsp_valid, rsp_grant, rsp_err, rsp_raz, viol_irq;
  logic [ADDR_W-1:0] viol_addr;

  int n_chk = 0, n_fail = 0;
  logic [NPART-1:0] m_own, m_ro, m_oth;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic exp_irq = 1'b0;

  always #4 clk = ~clk;

  part_guard #(.ADDR_W(ADDR_W), .PART_KB(16), .NPART(NPART)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode), .own_vec_i(own_v),
    .ro_vec_i(ro_v), .oth_rd_vec_i(oth_v), .silent_en_i(silent),
    .acc_valid_i(acc_valid), .acc_dom_i(acc_dom), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .viol_clr_i(viol_clr), .rsp_valid_o(rsp_valid),
    .rsp_grant_o(rsp_grant), .rsp_err_o(rsp_err), .rsp_raz_o(rsp_raz),
    .viol_addr_o(viol_addr), .viol_irq_o(viol_irq)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // verdict code: 4 grant, 2 error, 1 silent
  function automatic int exp_verdict(int field, bit dom, bit wr, bit sil, output string req);
    int p = (field > 15) ? 15 : field;
    bit o = m_own[p], r = m_ro[p], x = m_oth[p];
    bit ok;
    if (dom == o) begin ok = !wr || !r; req = "R2"; end
    else begin ok = (x != o) && !wr; req = "R3"; end
    if (field > 15) req = {req, "/R1"};
    if (ok) return 4;
    if (dom) begin req = {req, "/R5"}; return 2; end
    req = {req, "/R6"};
    return sil ? 1 : 2;
  endfunction

  task automatic load_map(logic [NPART-1:0] o, logic [NPART-1:0] r, logic [NPART-1:0] x);
    @(negedge clk);
    own_v = o; ro_v = r; oth_v = x; cfg_mode = 1'b1;
    @(negedge clk);
    cfg_mode = 1'b0;
    m_own = o; m_ro = r; m_oth = x;
  endtask

  task automatic access(int field, bit dom, bit wr, bit sil, bit clr);
    string req;
    int ev;
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(field) << OFFS;
    a = a | ADDR_W'((field * 613 + dom * 7 + wr) & 16'h3FFF);
    ev = exp_verdict(field, dom, wr, sil, req);
    @(negedge clk);
    acc_valid = 1'b1; acc_dom = dom; acc_write = wr; acc_addr = a;
    silent = sil; viol_clr = clr;
    @(negedge clk);
    acc_valid = 1'b0; viol_clr = 1'b0;
    if (ev != 4) begin exp_addr = a; exp_irq = 1'b1; end
    else if (clr) exp_irq = 1'b0;
    chk({req, "/R9"}, "verdict", {rsp_valid, rsp_grant, rsp_err, rsp_raz}, 8 + ev);
    chk({req, "/R7"}, "viol_addr", viol_addr, exp_addr);
    chk({req, "/R8"}, "viol_irq", viol_irq, exp_irq);
  endtask

  task automatic sweep();
    for (int f = 0; f < 20; f++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++)
            access(f, d[0], w[0], s[0], 1'b0);
    access(255, 1'b1, 1'b1, 1'b0, 1'b0);
    access(255, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    // R4: vectors present during reset are captured
    own_v = 16'hF0A5; ro_v = 16'h3C3C; oth_v = 16'h55AA;
    repeat (3) @(negedge clk);
    chk("R10", "outputs in reset", {rsp_valid, rsp_grant, rsp_err, rsp_raz, viol_irq, viol_addr}, 0);
    rst = 1'b0;
    m_own = 16'hF0A5; m_ro = 16'h3C3C; m_oth = 16'h55AA;
    @(negedge clk);
    // R4: later input changes with configuration mode low are ignored
    own_v = ~own_v; ro_v = ~ro_v; oth_v = ~oth_v;
    sweep();

    load_map(16'h00FF, 16'h0F0F, 16'h3333);
    sweep();
    load_map(16'hFFFF, 16'h0000, 16'hFFFF);
    sweep();
    load_map(16'h0000, 16'hFFFF, 16'hAAAA);
    sweep();

    // R8: clear with no violation drops the flag
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    exp_irq = 1'b0;
    chk("R8", "irq after clear", viol_irq, 0);
    chk("R7", "addr kept after clear", viol_addr, exp_addr);
    // R8: a violation in the same cycle as clear keeps the flag set
    access(3, 1'b1, 1'b1, 1'b0, 1'b1);
    // R8/R7: clear together with a granted access clears, address kept
    access(0, 1'b0, 1'b0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule